// File: doc/BRIEF.md
# Iterative Binary to BCD Converter

This block turns an 8-bit unsigned binary number into three packed BCD digits: hundreds, tens and units. It uses the shift-and-add-3 method. The method is spread over a few clock cycles, so no long combinational chain limits the clock rate. A one-cycle `start` pulse captures the input. The block then moves one binary bit per cycle into a BCD register. Before each move, every lower digit holding 5 or more gets 3 added to it. When the last bit is in, `done` pulses and the result appears on `bcd_out`.

The three top input bits go straight into the low end of the BCD register when the input is captured. Only the five remaining bits need a shift cycle each. The hundreds digit can never exceed 2, so it has no correction logic. No correction is applied after the last shift.

The controller has three states. In `S_IDLE` it waits for `start`. In `S_SHIFT` it does one correct-then-shift step per cycle. In `S_DONE` it signals completion for one cycle. There are three transitions:
- `S_IDLE` goes to `S_SHIFT` on a start (the accept transition).
- `S_SHIFT` goes to `S_DONE` when the fifth shift is taken (the finish transition).
- `S_DONE` goes back to `S_IDLE` unconditionally (the return transition).

Synchronous reset forces `S_IDLE` from any state.

Top module: `bin2bcd_seq`

## Requirements
- R1: For every input value 0..255, the result at `done` equals its decimal value. Hundreds sit in bits [11:8], tens in [7:4] and units in [3:0].
- R2: A `start` sampled high in idle is accepted. `done` is then high in the fifth cycle after the accepting edge, and only after the fifth shift edge.
- R3: `done` is high for exactly one cycle per accepted conversion.
- R4: After `done`, `bcd_out` keeps its value unchanged until the next accepted `start`.
- R5: A `start` that arrives while `busy` is high is ignored. The running conversion still finishes at its original time with the original input's result, and no second `done` follows.
- R6: Synchronous reset, applied even in mid-conversion, returns the block to idle with `busy` low, `done` low and `bcd_out` zero.
- R7: At `done`, bits [11:10] are zero, the hundreds digit is at most 2, and the tens and units digits are at most 9.
- R8: `busy` is high from the cycle after the accepting edge through the `done` cycle, and low in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion; honoured only when idle |
| bin_in | input | 8 | Binary value, sampled with an accepted `start` |
| busy | output | 1 | Conversion in progress (shift or done state) |
| done | output | 1 | One-cycle pulse: `bcd_out` holds the final result |
| bcd_out | output | 12 | Packed BCD result: hundreds, tens, units |

## Verification
On every cycle, the embedded assertions check these properties:
- `done` is a single-cycle pulse that returns to idle, as required by R3 and R8.
- The step counter never passes its last value.
- Every digit is within its legal range at completion, as required by R7.
- The output stays stable while idle with no start.

Only the bench scenarios can show the rest:
- The decimal correctness of the result over all 256 inputs (R1).
- The exact completion latency (R2).
- That a mid-conversion start leaves the first result untouched (R5).
- That reset aborts a running conversion (R6).

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_DONE  = 2'd2
    } conv_state_t;
endpackage

// File: rtl/bcd_nibble_fix.sv
module bcd_nibble_fix
    import bcd_pkg::*;
(
    input  logic [DIGIT_W-1:0] d,
    output logic [DIGIT_W-1:0] q
);
    // A digit of 5 or more overflows past 9 when doubled, so pre-bias it by 3.
    always_comb begin
        if (d > DIGIT_W'(4))
            q = d + DIGIT_W'(3);
        else
            q = d;
    end
endmodule

// File: rtl/bcd_adjust.sv
module bcd_adjust
    import bcd_pkg::*;
#(
    parameter int NUM_DIG = 3
) (
    input  logic [NUM_DIG*DIGIT_W-1:0] raw,
    output logic [NUM_DIG*DIGIT_W-1:0] fixed
);
    // All digits except the top one get a corrector.
    for (genvar i = 0; i < NUM_DIG - 1; i++) begin : g_fix
        bcd_nibble_fix u_fix (
            .d (raw  [i*DIGIT_W +: DIGIT_W]),
            .q (fixed[i*DIGIT_W +: DIGIT_W])
        );
    end

    // The top digit stays small enough that it never needs a correction.
    assign fixed[NUM_DIG*DIGIT_W-1 -: DIGIT_W] = raw[NUM_DIG*DIGIT_W-1 -: DIGIT_W];
endmodule

// File: rtl/bcd_ctrl.sv
module bcd_ctrl
    import bcd_pkg::*;
#(
    parameter int STEPS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic shift,
    output logic busy,
    output logic done
);
    localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    conv_state_t state, state_nx;
    logic [CW-1:0] step_cnt;

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // Step counter
    always_ff @(posedge clk) begin
        if (rst || load)
            step_cnt <= '0;
        else if (shift && step_cnt != LAST)
            step_cnt <= step_cnt + CW'(1);
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_SHIFT;
            S_SHIFT: if (step_cnt == LAST) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load  = 1'b0;
        shift = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        unique case (state)
            S_IDLE:  load = start;
            S_SHIFT: begin
                shift = 1'b1;
                busy  = 1'b1;
            end
            S_DONE:  begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

    // R3: completion is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: after done the block is idle again
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R2: the step counter stays inside its window
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        shift |-> step_cnt <= LAST);

    // R5: no load can happen while a conversion runs
    a_r5_no_reload: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load);
endmodule

// File: rtl/bin2bcd_seq.sv
module bin2bcd_seq
    import bcd_pkg::*;
#(
    parameter int IN_W    = 8,
    parameter int NUM_DIG = 3,
    parameter int PRE_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [IN_W-1:0]            bin_in,
    output logic                       busy,
    output logic                       done,
    output logic [NUM_DIG*DIGIT_W-1:0] bcd_out
);
    localparam int BCD_W = NUM_DIG * DIGIT_W;
    localparam int STEPS = IN_W - PRE_W;

    logic             load, shift;
    logic [BCD_W-1:0] bcd_q, bcd_fixed;
    logic [STEPS-1:0] src_q;

    bcd_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .load  (load),
        .shift (shift),
        .busy  (busy),
        .done  (done)
    );

    bcd_adjust #(.NUM_DIG(NUM_DIG)) u_adj (
        .raw   (bcd_q),
        .fixed (bcd_fixed)
    );

    // Datapath: preload the top bits, then correct-and-shift one bit per step
    always_ff @(posedge clk) begin
        if (rst) begin
            bcd_q <= '0;
            src_q <= '0;
        end else if (load) begin
            bcd_q <= {{(BCD_W-PRE_W){1'b0}}, bin_in[IN_W-1 -: PRE_W]};
            src_q <= bin_in[STEPS-1:0];
        end else if (shift) begin
            bcd_q <= {bcd_fixed[BCD_W-2:0], src_q[STEPS-1]};
            src_q <= {src_q[STEPS-2:0], 1'b0};
        end
    end

    assign bcd_out = bcd_q;

    // R7: legal digit ranges at completion
    a_r7_digit_range: assert property (@(posedge clk) disable iff (rst)
        done |-> (bcd_out[11:10] == 2'b00 && bcd_out[11:8] <= 4'd2
                  && bcd_out[7:4] <= 4'd9 && bcd_out[3:0] <= 4'd9));

    // R4: result holds while idle without a start
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(bcd_out));

    // R2: a conversion stays busy right after being accepted
    a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !done));
endmodule

// File: tb/bin2bcd_seq_bench.sv
module bin2bcd_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [7:0]  bin_in;
    logic        busy, done;
    logic [11:0] bcd_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bin2bcd_seq u_bin2bcd_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .bin_in  (bin_in),
        .busy    (busy),
        .done    (done),
        .bcd_out (bcd_out)
    );

    function automatic logic [11:0] exp_bcd(int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // One conversion; poke > 0 injects a start carrying another value at that busy cycle.
    task automatic convert(int v, int poke);
        int lat = 0;
        start  = 1'b1;
        bin_in = 8'(v);
        @(negedge clk);
        start = 1'b0;
        check("R8 busy after accept", {31'd0, busy}, 32'd1);
        for (int k = 1; k <= 20; k++) begin
            if (k == poke) begin
                start  = 1'b1;
                bin_in = ~8'(v);
            end
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                lat = k;
                break;
            end
        end
        check("R2 latency", lat, 5);
        check("R1 result", {20'd0, bcd_out}, {20'd0, exp_bcd(v)});
        check("R7 top bits zero", {30'd0, bcd_out[11:10]}, 32'd0);
        @(negedge clk);
        check("R3 done single", {31'd0, done}, 32'd0);
        check("R8 idle after done", {31'd0, busy}, 32'd0);
        if (poke > 0) begin
            repeat (6) @(negedge clk);
            check("R5 no second done", {31'd0, done | busy}, 32'd0);
        end
        check("R4 held", {20'd0, bcd_out}, {20'd0, exp_bcd(v)});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        rst = 1'b1;
        start = 1'b0;
        bin_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R6: reset state
        check("R6 reset busy", {31'd0, busy}, 32'd0);
        check("R6 reset done", {31'd0, done}, 32'd0);
        check("R6 reset bcd", {20'd0, bcd_out}, 32'd0);

        // Directed corners
        convert(0, 0);
        convert(255, 0);
        convert(199, 0);
        convert(100, 0);
        convert(99, 0);
        convert(5, 0);
        // R4: idle cycles keep the result
        repeat (4) @(negedge clk);
        check("R4 idle hold", {20'd0, bcd_out}, {20'd0, exp_bcd(5)});
        // R5: starts while busy, at several points
        convert(137, 2);
        convert(58, 4);
        convert(211, 5);

        // R1: exhaustive sweep
        for (int v = 0; v < 256; v++) convert(v, 0);

        // Random mix with occasional busy starts
        for (int i = 0; i < 200; i++) begin
            int v = int'($urandom_range(255));
            int p = (($urandom_range(3)) == 0) ? int'($urandom_range(5, 1)) : 0;
            convert(v, p);
        end

        // R6: reset during a conversion
        start = 1'b1;
        bin_in = 8'd87;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R6 abort busy", {31'd0, busy}, 32'd0);
        check("R6 abort done", {31'd0, done}, 32'd0);
        check("R6 abort bcd", {20'd0, bcd_out}, 32'd0);
        convert(87, 0);

        finish_run();
    end
endmodule